// File: doc/BRIEF.md
# Interrupting GPIO Bank

A bank of general-purpose pins behind a small word-addressed register interface. Each pin has an output data bit and a direction bit, and its input is brought into the clock domain through a two-flop synchronizer. Software changes single bits of the output, direction and interrupt-enable state atomically, through set and clear aliases: only the bits written as 1 change.

Each pin also has an event detector. Per-pin configuration bitmaps pick edge or level detection, rising/high or falling/low sensitivity, and an option to fire on both edges. Detected events are latched in a pending register that software clears by writing 1 to a bit. The pending bits are masked by the enable bits and combined into one interrupt line for the parent interrupt controller.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every readable register reads 0, `pin_out` and `pin_oe` are all 0 and `irq_out` is 0.
- R2: Offset 0x00 is the output data register and drives `pin_out`. A write to 0x40 sets, and a write to 0x44 clears, only the output bits written as 1. A read at 0x00, 0x40 or 0x44 returns the current output data.
- R3: Offset 0x08 is the direction register and drives `pin_oe`; a bit of 1 makes the pin an output. A write to 0x48 sets and a write to 0x4C clears only the bits written as 1. A read at 0x08, 0x48 or 0x4C returns the current direction.
- R4: A read at 0x04 returns `pin_in` through a two-flop synchronizer. A change made between two clock edges is not visible after the first edge and is visible after the second.
- R5: Offset 0x28 is the interrupt enable register. A write to 0x30 sets and a write to 0x34 clears only the bits written as 1. A read at 0x28, 0x30 or 0x34 returns the current enables.
- R6: In edge mode (bit of 0x2C = 0) with the both-edges bit of 0x1C at 0, a pin with polarity bit 0 in 0x18 latches a pending event on a rising synchronized input only. A pin with polarity bit 1 latches on a falling input only.
- R7: With the both-edges bit of 0x1C at 1, an edge-mode pin latches a pending event on rising and on falling inputs, whatever its polarity bit.
- R8: In level mode (bit of 0x2C = 1), a pin sets its pending bit in every cycle its synchronized input is active: high for polarity 0, low for polarity 1. The bit stays latched after the input goes inactive.
- R9: Offset 0x20 reads one pending bit per pin. Writing 1 to a bit clears it, and writing 0 leaves it alone. If an event arrives in the same cycle as the clear, the bit stays set.
- R10: `irq_out` is high exactly when some pin has both its pending bit and its enable bit set. Events on disabled pins are still latched.
- R11: Offset 0x24 is a plain 32-bit read/write register that has no effect on the pins or the interrupt. Any offset outside the map reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | ADDR_W (8) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS (32) | Raw pin inputs |
| pin_out | output | NPINS (32) | Output data to the pads |
| pin_oe | output | NPINS (32) | Output enables to the pads |
| irq_out | output | 1 | Combined interrupt to the parent controller |

## Verification
A wrong previous-sample or synchronizer bit shows up as a pending bit that is missing or unexpected. It becomes visible at 0x20 and on `irq_out` three edges after the pin changes. A set/clear alias that touches bits written as 0 corrupts `pin_out`, `pin_oe` or the enables on the next edge. A clear that beats a coincident event shows as a level-mode pending bit that reads 0 on the cycle after the acknowledge. Each pin is swept on its own so that a bit-lane swap or a stuck lane in any of these paths shows as a one-hot mismatch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int unsigned DATA_W = 32;

   localparam logic [7:0] OFF_DOUT     = 8'h00;
   localparam logic [7:0] OFF_DIN      = 8'h04;
   localparam logic [7:0] OFF_DIR      = 8'h08;
   localparam logic [7:0] OFF_POL      = 8'h18;
   localparam logic [7:0] OFF_DUAL     = 8'h1C;
   localparam logic [7:0] OFF_PEND     = 8'h20;
   localparam logic [7:0] OFF_ROUTE    = 8'h24;
   localparam logic [7:0] OFF_IEN      = 8'h28;
   localparam logic [7:0] OFF_MODE     = 8'h2C;
   localparam logic [7:0] OFF_IEN_SET  = 8'h30;
   localparam logic [7:0] OFF_IEN_CLR  = 8'h34;
   localparam logic [7:0] OFF_DOUT_SET = 8'h40;
   localparam logic [7:0] OFF_DOUT_CLR = 8'h44;
   localparam logic [7:0] OFF_DIR_SET  = 8'h48;
   localparam logic [7:0] OFF_DIR_CLR  = 8'h4C;

   typedef enum logic {TRIG_EDGE = 1'b0, TRIG_LEVEL = 1'b1} trig_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= d_i;
         else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_i,
   input  logic [W-1:0] mode_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] dual_i,
   output logic [W-1:0] evt_o
);
   import gpio_bank_pkg::*;

   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sync_i;
   end

   for (genvar p = 0; p < W; p++) begin : g_pin
      logic rise, fall, active;
      always_comb begin
         rise   = sync_i[p] & ~prev_q[p];
         fall   = ~sync_i[p] & prev_q[p];
         active = sync_i[p] ^ pol_i[p];
         if (trig_e'(mode_i[p]) == TRIG_LEVEL) evt_o[p] = active;
         else if (dual_i[p])                   evt_o[p] = rise | fall;
         else if (pol_i[p])                    evt_o[p] = fall;
         else                                  evt_o[p] = rise;
      end
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [gpio_bank_pkg::DATA_W-1:0]  wdata_i,
   output logic [gpio_bank_pkg::DATA_W-1:0]  rdata_o,
   input  logic [NPINS-1:0]                  sync_i,
   input  logic [NPINS-1:0]                  evt_i,
   output logic [NPINS-1:0]                  dout_o,
   output logic [NPINS-1:0]                  dir_o,
   output logic [NPINS-1:0]                  pol_o,
   output logic [NPINS-1:0]                  dual_o,
   output logic [NPINS-1:0]                  mode_o,
   output logic [NPINS-1:0]                  ien_o,
   output logic [NPINS-1:0]                  pend_o
);
   import gpio_bank_pkg::*;

   logic [NPINS-1:0]  wm;
   logic [NPINS-1:0]  ack;
   logic [DATA_W-1:0] route_q;

   assign wm  = wdata_i[NPINS-1:0];
   assign ack = (we_i && addr_i == ADDR_W'(OFF_PEND)) ? wm : '0;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
      return a == ADDR_W'(off);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_o  <= '0;
         dir_o   <= '0;
         pol_o   <= '0;
         dual_o  <= '0;
         mode_o  <= '0;
         ien_o   <= '0;
         route_q <= '0;
      end else if (we_i) begin
         if (hit(addr_i, OFF_DOUT))     dout_o  <= wm;
         if (hit(addr_i, OFF_DOUT_SET)) dout_o  <= dout_o | wm;
         if (hit(addr_i, OFF_DOUT_CLR)) dout_o  <= dout_o & ~wm;
         if (hit(addr_i, OFF_DIR))      dir_o   <= wm;
         if (hit(addr_i, OFF_DIR_SET))  dir_o   <= dir_o | wm;
         if (hit(addr_i, OFF_DIR_CLR))  dir_o   <= dir_o & ~wm;
         if (hit(addr_i, OFF_IEN))      ien_o   <= wm;
         if (hit(addr_i, OFF_IEN_SET))  ien_o   <= ien_o | wm;
         if (hit(addr_i, OFF_IEN_CLR))  ien_o   <= ien_o & ~wm;
         if (hit(addr_i, OFF_POL))      pol_o   <= wm;
         if (hit(addr_i, OFF_DUAL))     dual_o  <= wm;
         if (hit(addr_i, OFF_MODE))     mode_o  <= wm;
         if (hit(addr_i, OFF_ROUTE))    route_q <= wdata_i;
      end
   end

   // New events take priority over an acknowledge in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= (pend_o & ~ack) | evt_i;
   end

   always_comb begin
      rdata_o = '0;
      if (hit(addr_i, OFF_DOUT) || hit(addr_i, OFF_DOUT_SET) || hit(addr_i, OFF_DOUT_CLR))
         rdata_o[NPINS-1:0] = dout_o;
      else if (hit(addr_i, OFF_DIR) || hit(addr_i, OFF_DIR_SET) || hit(addr_i, OFF_DIR_CLR))
         rdata_o[NPINS-1:0] = dir_o;
      else if (hit(addr_i, OFF_IEN) || hit(addr_i, OFF_IEN_SET) || hit(addr_i, OFF_IEN_CLR))
         rdata_o[NPINS-1:0] = ien_o;
      else if (hit(addr_i, OFF_DIN))  rdata_o[NPINS-1:0] = sync_i;
      else if (hit(addr_i, OFF_POL))  rdata_o[NPINS-1:0] = pol_o;
      else if (hit(addr_i, OFF_DUAL)) rdata_o[NPINS-1:0] = dual_o;
      else if (hit(addr_i, OFF_MODE)) rdata_o[NPINS-1:0] = mode_o;
      else if (hit(addr_i, OFF_PEND)) rdata_o[NPINS-1:0] = pend_o;
      else if (hit(addr_i, OFF_ROUTE)) rdata_o = route_q;
   end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              bus_we,
   input  logic [ADDR_W-1:0]                 bus_addr,
   input  logic [gpio_bank_pkg::DATA_W-1:0]  bus_wdata,
   output logic [gpio_bank_pkg::DATA_W-1:0]  bus_rdata,
   input  logic [NPINS-1:0]                  pin_in,
   output logic [NPINS-1:0]                  pin_out,
   output logic [NPINS-1:0]                  pin_oe,
   output logic                              irq_out
);
   import gpio_bank_pkg::*;

   if (NPINS < 1 || NPINS > DATA_W) begin : g_bad_npins
      $error("gpio_irq_bank: NPINS must be in 1..DATA_W");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must be at least 8");
   end

   logic [NPINS-1:0] sync_w, evt_w, pol_w, dual_w, mode_w, ien_q, pend_q;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(sync_w)
   );

   gpio_evt_detect #(.W(NPINS)) u_detect (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_w), .mode_i(mode_w),
      .pol_i(pol_w), .dual_i(dual_w), .evt_o(evt_w)
   );

   gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
      .wdata_i(bus_wdata), .rdata_o(bus_rdata), .sync_i(sync_w), .evt_i(evt_w),
      .dout_o(pin_out), .dir_o(pin_oe), .pol_o(pol_w), .dual_o(dual_w),
      .mode_o(mode_w), .ien_o(ien_q), .pend_o(pend_q)
   );

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_out <= 1'b0;
         else        irq_out <= |(pend_q & ien_q);
      end
   end else begin : g_irq_comb
      assign irq_out = |(pend_q & ien_q);
   end
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
   parameter int unsigned NPINS  = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              bus_we,
   input logic [ADDR_W-1:0]                 bus_addr,
   input logic [gpio_bank_pkg::DATA_W-1:0]  bus_wdata,
   input logic [NPINS-1:0]                  pin_out,
   input logic [NPINS-1:0]                  pin_oe,
   input logic [NPINS-1:0]                  ien_q,
   input logic [NPINS-1:0]                  pend_q,
   input logic                              irq_out
);
   import gpio_bank_pkg::*;

   logic [NPINS-1:0] wm;
   logic hit_oset, hit_oclr, hit_dset, hit_eset, hit_eclr, hit_pend;

   assign wm       = bus_wdata[NPINS-1:0];
   assign hit_oset = bus_we && bus_addr == ADDR_W'(OFF_DOUT_SET);
   assign hit_oclr = bus_we && bus_addr == ADDR_W'(OFF_DOUT_CLR);
   assign hit_dset = bus_we && bus_addr == ADDR_W'(OFF_DIR_SET);
   assign hit_eset = bus_we && bus_addr == ADDR_W'(OFF_IEN_SET);
   assign hit_eclr = bus_we && bus_addr == ADDR_W'(OFF_IEN_CLR);
   assign hit_pend = bus_we && bus_addr == ADDR_W'(OFF_PEND);

   // R2
   out_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_oset |=> ((pin_out & $past(wm)) == $past(wm)));
   // R2
   out_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_oclr |=> ((pin_out & $past(wm)) == '0));
   // R3
   dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_dset |=> ((pin_oe & $past(wm)) == $past(wm)));
   // R5
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_eset |=> ((ien_q & $past(wm)) == $past(wm)));
   // R5
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_eclr |=> ((ien_q & $past(wm)) == '0));
   // R9
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_pend |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
   // R10
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_q == '0 && $past(ien_q) == '0) |-> !irq_out);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
   .ien_q(ien_q), .pend_q(pend_q), .irq_out(irq_out)
);

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pins = '0;
   logic [31:0] pout, poe;
   logic        irq;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   always #2.5 clk = ~clk;

   gpio_irq_bank u_dut (
      .clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr),
      .bus_wdata(wdata), .bus_rdata(rdata), .pin_in(pins),
      .pin_out(pout), .pin_oe(poe), .irq_out(irq)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog got=%0d exp=<100000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);

      // R1 reset state
      foreach (u_offs[k]) rdchk("R1 reset read", u_offs[k], 32'h0);
      chk("R1 pin_out", pout, 32'h0);
      chk("R1 pin_oe", poe, 32'h0);
      chk("R1 irq", {31'h0, irq}, 32'h0);

      // R2 output data and aliases
      wr(8'h00, 32'hA5A5_0F0F);
      rdchk("R2 dout", 8'h00, 32'hA5A5_0F0F);
      wr(8'h40, 32'h0000_F0F0);
      rdchk("R2 set alias", 8'h40, 32'hA5A5_FFFF);
      wr(8'h44, 32'hA500_0000);
      rdchk("R2 clr alias", 8'h44, 32'h00A5_FFFF);
      chk("R2 pin_out", pout, 32'h00A5_FFFF);

      // R3 direction
      wr(8'h08, 32'h0000_00FF);
      wr(8'h48, 32'h0000_0100);
      rdchk("R3 dir set", 8'h48, 32'h0000_01FF);
      wr(8'h4C, 32'h0000_0001);
      rdchk("R3 dir clr", 8'h08, 32'h0000_01FE);
      chk("R3 pin_oe", poe, 32'h0000_01FE);

      // R4 two-flop input path
      pins = 32'h1234_5678;
      wait_n(1);
      rdchk("R4 after one edge", 8'h04, 32'h0);
      wait_n(1);
      rdchk("R4 after two edges", 8'h04, 32'h1234_5678);
      pins = '0;
      wait_n(4);
      wr(8'h20, 32'hFFFF_FFFF);
      rdchk("R9 clear all", 8'h20, 32'h0);

      // R5 enables
      wr(8'h28, 32'h0000_000F);
      wr(8'h30, 32'h0000_00F0);
      rdchk("R5 en set", 8'h30, 32'h0000_00FF);
      wr(8'h34, 32'h0000_0003);
      rdchk("R5 en clr", 8'h34, 32'h0000_00FC);

      // R6 / R10 rising-edge sweep over every pin
      wr(8'h28, 32'hFFFF_FFFF);
      for (int i = 0; i < 32; i++) begin
         pins = 32'h1 << i;
         wait_n(4);
         rdchk("R6 rising capture", 8'h20, 32'h1 << i);
         chk("R10 irq on", {31'h0, irq}, 32'h1);
         wr(8'h20, 32'h1 << i);
         rdchk("R9 ack", 8'h20, 32'h0);
         chk("R10 irq off", {31'h0, irq}, 32'h0);
         pins = '0;
         wait_n(4);
         rdchk("R6 falling ignored", 8'h20, 32'h0);
      end

      // R6 falling polarity
      wr(8'h18, 32'hFFFF_FFFF);
      pins = 32'h8;
      wait_n(4);
      rdchk("R6 rise ignored neg", 8'h20, 32'h0);
      pins = '0;
      wait_n(4);
      rdchk("R6 falling capture", 8'h20, 32'h8);
      wr(8'h20, 32'h8);

      // R7 both edges, polarity ignored
      wr(8'h1C, 32'h20);
      pins = 32'h20;
      wait_n(4);
      rdchk("R7 dual rise", 8'h20, 32'h20);
      wr(8'h20, 32'h20);
      pins = '0;
      wait_n(4);
      rdchk("R7 dual fall", 8'h20, 32'h20);
      wr(8'h20, 32'h20);
      wr(8'h1C, 32'h0);
      wr(8'h18, 32'h0);

      // R10 latched while disabled
      wr(8'h34, 32'hFFFF_FFFF);
      pins = 32'h40;
      wait_n(4);
      rdchk("R10 latched disabled", 8'h20, 32'h40);
      chk("R10 irq masked", {31'h0, irq}, 32'h0);
      wr(8'h30, 32'h40);
      chk("R10 irq after enable", {31'h0, irq}, 32'h1);
      wr(8'h20, 32'h40);
      chk("R10 irq after ack", {31'h0, irq}, 32'h0);
      pins = '0;
      wait_n(4);

      // R8 / R9 level mode
      wr(8'h2C, 32'h80);
      pins = 32'h80;
      wait_n(4);
      rdchk("R8 level high", 8'h20, 32'h80);
      wr(8'h20, 32'h80);
      rdchk("R9 event beats ack", 8'h20, 32'h80);
      pins = '0;
      wait_n(4);
      rdchk("R8 latched after deassert", 8'h20, 32'h80);
      wr(8'h20, 32'h80);
      rdchk("R8 ack after deassert", 8'h20, 32'h0);
      wr(8'h18, 32'h80);
      wait_n(2);
      rdchk("R8 level low", 8'h20, 32'h80);
      wr(8'h18, 32'h0);
      wr(8'h2C, 32'h0);
      wr(8'h20, 32'hFFFF_FFFF);
      rdchk("R8 cleared", 8'h20, 32'h0);

      // R11 scratch and unmapped
      wr(8'h24, 32'hDEAD_BEEF);
      rdchk("R11 route rw", 8'h24, 32'hDEAD_BEEF);
      chk("R11 route no pin effect", pout, 32'h00A5_FFFF);
      chk("R11 route no irq effect", {31'h0, irq}, 32'h0);
      rdchk("R11 unmapped 0x10", 8'h10, 32'h0);
      rdchk("R11 unmapped 0x3C", 8'h3C, 32'h0);
      rdchk("R11 unmapped 0xFC", 8'hFC, 32'h0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   logic [7:0] u_offs [15] = '{8'h00, 8'h04, 8'h08, 8'h18, 8'h1C, 8'h20, 8'h24,
                              8'h28, 8'h2C, 8'h30, 8'h34, 8'h40, 8'h44, 8'h48, 8'h4C};
endmodule